// File: doc/BRIEF.md
# Flash Program/Erase Timing Sequencer

This block drives the program and erase strobes of a flash array model and holds each phase for a fixed number of timing-generator ticks. The ticks arrive as a one-cycle `tick` enable in the system clock domain. The host gives one command per operation: program one word or byte, a block write, a segment erase, or a mass erase. The block raises `busy` for the whole operation. When `busy` falls it pulses `done` for one cycle.

During a block write, the host keeps the next data word ready on `blk_data` and holds `blk_avail` high. When the current word completes, the sequencer takes that word (`blk_take`) and programs it at the next address. If no word is ready, or the next address would leave the aligned 64-byte block, the sequencer runs the closing wait and returns to idle.

One 64-byte information segment carries calibration data. It is locked against program and erase after every reset. An explicit unlock pulse opens it and a relock pulse closes it again. A command that targets the locked segment is rejected with a one-cycle `acc_viol` pulse, and so is any command issued while busy.

Top module: `flash_seq_ctrl`

## Requirements
- R1: A single word/byte program holds `prog_en` high for exactly 30 ticks. It presents the command's address, data and byte flag on `arr_addr`, `arr_data` and `arr_byte`.
- R2: In a block write, the first word takes 25 ticks and each further word takes 18 ticks, with `prog_en` high. A closing wait of 6 ticks follows, during which `busy` stays high while `prog_en` and `erase_en` are low.
- R3: When a block word completes, the sequencer continues only if `blk_avail` is high and the next address lies in the same 64-byte aligned block. In that case `blk_take` pulses for one cycle, `arr_addr` advances by 2 (word) or 1 (byte), and `arr_data` takes `blk_data`. Otherwise the closing wait starts.
- R4: A segment erase holds `erase_en` high for 4819 ticks, with `mass_en` low. `arr_addr` is the segment base: the address aligned to 64 bytes inside the information region 0x1000–0x10FF, and to 512 bytes elsewhere.
- R5: A mass erase (`cmd_op`=3) holds `erase_en` and `mass_en` high for 10593 ticks. `keep_lock_seg` is 1 exactly when the locked segment was locked at the command.
- R6: The segment 0x10C0–0x10FF is locked after reset. While it is locked, a word program (`cmd_op`=0), block write (`cmd_op`=1) or segment erase (`cmd_op`=2) addressed into it gives a one-cycle `acc_viol` pulse and leaves `busy` low. `unlock_req` unlocks it and `relock_req` locks it, with relock winning when both are high.
- R7: A command issued while `busy` is high gives a one-cycle `acc_viol` pulse. It does not alter the running operation's address, strobes or duration.
- R8: `busy` rises in the cycle after a command is accepted. `done` is high for exactly one cycle, the first cycle in which `busy` is low again.
- R9: Only cycles with `tick` high advance a phase, so a phase of N ticks ends on its Nth tick whatever the tick spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle timing-generator tick enable |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 word program, 1 block write, 2 segment erase, 3 mass erase |
| cmd_byte | input | 1 | Byte (1) or word (0) access |
| cmd_addr | input | 16 | Byte address of the command |
| cmd_data | input | 16 | Program data of the command |
| blk_avail | input | 1 | Next block word is ready |
| blk_data | input | 16 | Next block word |
| unlock_req | input | 1 | Unlock the calibration segment |
| relock_req | input | 1 | Lock the calibration segment |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse at end of operation |
| acc_viol | output | 1 | One-cycle pulse for a rejected command |
| blk_take | output | 1 | One-cycle pulse when a block word is consumed |
| prog_en | output | 1 | Program strobe to the array |
| erase_en | output | 1 | Erase strobe to the array |
| mass_en | output | 1 | Erase covers the whole array |
| keep_lock_seg | output | 1 | Mass erase must spare the locked segment |
| arr_addr | output | 16 | Array address |
| arr_data | output | 16 | Array program data |
| arr_byte | output | 1 | Array byte access |

## Verification
The assertions take it for granted that `tick` and `cmd_valid` are synchronous one-cycle-or-longer levels sampled only at clock edges. They also assume that `blk_data` is stable whenever `blk_avail` is high at a word completion. The stimulus drives every input shortly after a rising edge, so each input stays constant across one full clock period. It refreshes `blk_data` and `blk_avail` well within the 18-tick window, right after each observed `blk_take`. Block starts are placed at offsets close to a 64-byte boundary, and once in byte mode, so that the boundary rule ends the block before the supply of words runs out.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {
    OP_WORD  = 2'd0,
    OP_BLOCK = 2'd1,
    OP_SEG   = 2'd2,
    OP_MASS  = 2'd3
  } fop_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WORD,
    S_BFIRST,
    S_BNEXT,
    S_BEND,
    S_ERASE
  } fst_e;
endpackage

// File: rtl/fseq_region.sv
module fseq_region #(
  parameter int ADDR_W     = 16,
  parameter int INFO_BASE  = 'h1000,
  parameter int INFO_BYTES = 256,
  parameter int INFO_SEG   = 64,
  parameter int MAIN_SEG   = 512,
  parameter int LOCK_BASE  = 'h10C0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_lock,
  output logic [ADDR_W-1:0] seg_base
);
  localparam int INFO_SH = $clog2(INFO_SEG);
  localparam logic [ADDR_W-1:0] INFO_LO   = ADDR_W'(INFO_BASE);
  localparam logic [ADDR_W-1:0] INFO_HI   = ADDR_W'(INFO_BASE + INFO_BYTES - 1);
  localparam logic [ADDR_W-1:0] INFO_MASK = ~ADDR_W'(INFO_SEG - 1);
  localparam logic [ADDR_W-1:0] MAIN_MASK = ~ADDR_W'(MAIN_SEG - 1);
  localparam logic [ADDR_W-1:0] LOCK_ADR  = ADDR_W'(LOCK_BASE);

  logic in_info;

  always_comb begin
    in_info  = (addr >= INFO_LO) && (addr <= INFO_HI);
    in_lock  = (addr[ADDR_W-1:INFO_SH] == LOCK_ADR[ADDR_W-1:INFO_SH]);
    seg_base = in_info ? (addr & INFO_MASK) : (addr & MAIN_MASK);
  end
endmodule

// File: rtl/fseq_ticks.sv
module fseq_ticks #(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          fin
);
  logic [CW-1:0] cnt;

  assign fin = en && tick && (cnt == limit - CW'(1));

  always_ff @(posedge clk) begin
    if (rst || clr || fin) cnt <= '0;
    else if (en && tick)   cnt <= cnt + CW'(1);
  end

  AST_COUNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
    en |-> (cnt < limit)); // R9
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int T_WORD     = 30,
  parameter int T_BLK0     = 25,
  parameter int T_BLK1     = 18,
  parameter int T_BEND     = 6,
  parameter int T_SEG      = 4819,
  parameter int T_MASS     = 10593,
  parameter int BLK_BYTES  = 64,
  parameter int INFO_BASE  = 'h1000,
  parameter int INFO_BYTES = 256,
  parameter int INFO_SEG   = 64,
  parameter int MAIN_SEG   = 512,
  parameter int LOCK_BASE  = 'h10C0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic              cmd_byte,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              blk_avail,
  input  logic [DATA_W-1:0] blk_data,
  input  logic              unlock_req,
  input  logic              relock_req,
  output logic              busy,
  output logic              done,
  output logic              acc_viol,
  output logic              blk_take,
  output logic              prog_en,
  output logic              erase_en,
  output logic              mass_en,
  output logic              keep_lock_seg,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data,
  output logic              arr_byte
);
  localparam int TM1    = (T_MASS > T_SEG) ? T_MASS : T_SEG;
  localparam int TM2    = (TM1 > T_WORD) ? TM1 : T_WORD;
  localparam int CW     = $clog2(TM2 + 1);
  localparam int BLK_SH = $clog2(BLK_BYTES);
  localparam int WSTEP  = DATA_W / 8;
  localparam int INFO_SH = $clog2(INFO_SEG);
  localparam logic [ADDR_W-1:0] LOCK_ADR = ADDR_W'(LOCK_BASE);

  fst_e              state, nxt;
  logic              locked;
  logic              viol_n, take_n, accept;
  logic              cmd_lock_hit, at_bound, fin;
  logic [ADDR_W-1:0] cmd_seg_base, nxt_addr;
  logic [CW-1:0]     limit;
  fop_e              op;

  assign op = fop_e'(cmd_op);

  fseq_region #(
    .ADDR_W(ADDR_W), .INFO_BASE(INFO_BASE), .INFO_BYTES(INFO_BYTES),
    .INFO_SEG(INFO_SEG), .MAIN_SEG(MAIN_SEG), .LOCK_BASE(LOCK_BASE)
  ) u_region (
    .addr     (cmd_addr),
    .in_lock  (cmd_lock_hit),
    .seg_base (cmd_seg_base)
  );

  fseq_ticks #(.CW(CW)) u_ticks (
    .clk   (clk),
    .rst   (rst),
    .clr   (state == S_IDLE),
    .en    (state != S_IDLE),
    .tick  (tick),
    .limit (limit),
    .fin   (fin)
  );

  always_comb begin
    nxt_addr = arr_addr + (arr_byte ? ADDR_W'(1) : ADDR_W'(WSTEP));
    at_bound = (nxt_addr[BLK_SH-1:0] == '0);
    unique case (state)
      S_WORD:   limit = CW'(T_WORD);
      S_BFIRST: limit = CW'(T_BLK0);
      S_BNEXT:  limit = CW'(T_BLK1);
      S_BEND:   limit = CW'(T_BEND);
      S_ERASE:  limit = mass_en ? CW'(T_MASS) : CW'(T_SEG);
      default:  limit = CW'(1);
    endcase
  end

  always_comb begin
    nxt    = state;
    viol_n = 1'b0;
    take_n = 1'b0;
    accept = 1'b0;
    unique case (state)
      S_IDLE: if (cmd_valid) begin
        if (op != OP_MASS && cmd_lock_hit && locked) viol_n = 1'b1;
        else begin
          accept = 1'b1;
          unique case (op)
            OP_WORD:  nxt = S_WORD;
            OP_BLOCK: nxt = S_BFIRST;
            default:  nxt = S_ERASE;
          endcase
        end
      end
      S_WORD, S_ERASE, S_BEND: begin
        viol_n = cmd_valid;
        if (fin) nxt = S_IDLE;
      end
      default: begin
        viol_n = cmd_valid;
        if (fin) begin
          if (blk_avail && !at_bound) begin
            nxt    = S_BNEXT;
            take_n = 1'b1;
          end else nxt = S_BEND;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= S_IDLE;
      locked        <= 1'b1;
      busy          <= 1'b0;
      done          <= 1'b0;
      acc_viol      <= 1'b0;
      blk_take      <= 1'b0;
      prog_en       <= 1'b0;
      erase_en      <= 1'b0;
      mass_en       <= 1'b0;
      keep_lock_seg <= 1'b0;
      arr_addr      <= '0;
      arr_data      <= '0;
      arr_byte      <= 1'b0;
    end else begin
      state    <= nxt;
      busy     <= (nxt != S_IDLE);
      done     <= busy && (nxt == S_IDLE);
      acc_viol <= viol_n;
      blk_take <= take_n;
      prog_en  <= (nxt == S_WORD) || (nxt == S_BFIRST) || (nxt == S_BNEXT);
      erase_en <= (nxt == S_ERASE);
      if (relock_req)      locked <= 1'b1;
      else if (unlock_req) locked <= 1'b0;
      if (accept) begin
        arr_addr      <= (op == OP_SEG) ? cmd_seg_base : cmd_addr;
        arr_data      <= cmd_data;
        arr_byte      <= cmd_byte;
        mass_en       <= (op == OP_MASS);
        keep_lock_seg <= (op == OP_MASS) && locked;
      end else if (take_n) begin
        arr_addr <= nxt_addr;
        arr_data <= blk_data;
      end else if (nxt == S_IDLE) begin
        mass_en       <= 1'b0;
        keep_lock_seg <= 1'b0;
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R8
  AST_VIOL_FROM_CMD: assert property (@(posedge clk) disable iff (rst)
    acc_viol |-> $past(cmd_valid)); // R7
  AST_TAKE_IN_BLOCK: assert property (@(posedge clk) disable iff (rst)
    blk_take |-> (prog_en && arr_addr[BLK_SH-1:0] != '0)); // R3
  AST_NO_LOCKED_START: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && !mass_en) |->
      !($past(locked) && arr_addr[ADDR_W-1:INFO_SH] == LOCK_ADR[ADDR_W-1:INFO_SH])); // R6
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    (prog_en || erase_en) |-> busy); // R2
endmodule

// File: tb/tb_flash_seq_ctrl.sv
`timescale 1ns/1ps
module tb_flash_seq_ctrl;
  import flash_seq_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic        cmd_byte = 1'b0;
  logic [15:0] cmd_addr = '0;
  logic [15:0] cmd_data = '0;
  logic        blk_avail = 1'b0;
  logic [15:0] blk_data = '0;
  logic        unlock_req = 1'b0;
  logic        relock_req = 1'b0;
  logic        busy, done, acc_viol, blk_take, prog_en, erase_en, mass_en, keep_lock_seg, arr_byte;
  logic [15:0] arr_addr, arr_data;

  flash_seq_ctrl dut (
    .clk(clk), .rst(rst), .tick(tick), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_byte(cmd_byte), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .blk_avail(blk_avail), .blk_data(blk_data), .unlock_req(unlock_req),
    .relock_req(relock_req), .busy(busy), .done(done), .acc_viol(acc_viol),
    .blk_take(blk_take), .prog_en(prog_en), .erase_en(erase_en), .mass_en(mass_en),
    .keep_lock_seg(keep_lock_seg), .arr_addr(arr_addr), .arr_data(arr_data),
    .arr_byte(arr_byte)
  );

  always #4 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0, tick_div = 1, tphase = 0;

  always @(posedge clk) begin
    #1;
    tphase++;
    tick = ((tphase % tick_div) == 0);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run did not finish (act %0d cycles, exp < 150000)", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act %0h exp %0h", tag, act, exp);
    end
  endtask

  int r_ticks, r_takes, r_cyc, r_end, r_viol, r_done, r_done2, r_inj;
  logic [15:0] r_addr, r_mid_addr;
  logic r_pr, r_er, r_mass, r_keep, r_byte, r_mid_er, r_bad;

  task automatic issue(input logic [1:0] op, input logic [15:0] a, input logic [15:0] d,
                       input logic by);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d; cmd_byte = by;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_op(input logic [1:0] op, input logic [15:0] a, input logic [15:0] d,
                        input logic by, input int n_more);
    int stride;
    stride = by ? 1 : 2;
    r_ticks = 0; r_takes = 0; r_cyc = 0; r_end = 0; r_viol = 0; r_bad = 0;
    r_pr = 0; r_er = 0; r_mass = 0; r_keep = 0; r_addr = '0; r_byte = 0;
    blk_avail = (n_more > 0);
    blk_data  = d + 16'd1;
    issue(op, a, d, by);
    while (busy && r_cyc < 30000) begin
      r_cyc++;
      if (r_cyc == 1) begin
        r_addr = arr_addr; r_mass = mass_en; r_keep = keep_lock_seg; r_byte = arr_byte;
        if (arr_data !== d) r_bad = 1;
      end
      if (tick) r_ticks++;
      if (tick && !prog_en && !erase_en) r_end++;
      if (prog_en) r_pr = 1;
      if (erase_en) r_er = 1;
      if (blk_take) begin
        r_takes++;
        if (arr_addr !== a + 16'(stride * r_takes)) r_bad = 1;
        if (arr_data !== d + 16'(r_takes)) r_bad = 1;
        blk_data  = d + 16'(r_takes + 1);
        blk_avail = (r_takes < n_more);
      end
      if (r_inj != 0 && r_cyc == 10) begin
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_addr = 16'hF000; cmd_data = 16'h1111;
      end
      if (r_inj != 0 && r_cyc == 11) begin
        cmd_valid = 1'b0;
        r_viol = acc_viol; r_mid_addr = arr_addr; r_mid_er = erase_en;
      end
      @(negedge clk);
    end
    blk_avail = 1'b0;
    r_done = done;
    @(negedge clk);
    r_done2 = done;
  endtask

  task automatic expect_reject(input string tag, input logic [1:0] op, input logic [15:0] a);
    issue(op, a, 16'h5A5A, 1'b0);
    chk({tag, " viol pulse"}, acc_viol, 1);
    chk({tag, " stays idle"}, busy, 0);
    @(negedge clk);
    chk({tag, " viol one cycle"}, acc_viol, 0);
    chk({tag, " no start"}, busy, 0);
  endtask

  task automatic pulse(input logic u, input logic r);
    @(negedge clk);
    unlock_req = u; relock_req = r;
    @(negedge clk);
    unlock_req = 0; relock_req = 0;
  endtask

  initial begin
    r_inj = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R8 reset busy", busy, 0);
    chk("R8 reset done", done, 0);
    chk("R6 reset viol", acc_viol, 0);
    chk("R1 reset strobes", {prog_en, erase_en, mass_en}, 0);

    // R1 word program, tick every cycle
    run_op(2'd0, 16'hF802, 16'hBEEF, 1'b0, 0);
    chk("R1 word ticks", r_ticks, 30);
    chk("R1 word cycles", r_cyc, 30);
    chk("R1 word addr", r_addr, 16'hF802);
    chk("R1 word data ok", r_bad, 0);
    chk("R1 prog strobe", {r_pr, r_er}, 2'b10);
    chk("R8 done pulse", r_done, 1);
    chk("R8 done one cycle", r_done2, 0);

    // R9 sparse ticks
    tick_div = 3;
    run_op(2'd0, 16'hF901, 16'h00A5, 1'b1, 0);
    chk("R9 sparse ticks", r_ticks, 30);
    chk("R9 sparse cycles long", r_cyc >= 88, 1);
    chk("R1 byte flag", r_byte, 1);
    tick_div = 1;

    // R4 segment erase main and info
    run_op(2'd2, 16'hF9AB, 16'h0, 1'b0, 0);
    chk("R4 main seg ticks", r_ticks, 4819);
    chk("R4 main seg base", r_addr, 16'hF800);
    chk("R4 erase strobe", {r_pr, r_er, r_mass}, 3'b010);
    run_op(2'd2, 16'h1085, 16'h0, 1'b0, 0);
    chk("R4 info seg base", r_addr, 16'h1080);
    chk("R4 info seg ticks", r_ticks, 4819);

    // R2 R3 block writes
    run_op(2'd1, 16'hF810, 16'h2000, 1'b0, 3);
    chk("R2 block ticks", r_ticks, 25 + 3 * 18 + 6);
    chk("R2 end ticks", r_end, 6);
    chk("R3 takes", r_takes, 3);
    chk("R3 addr/data", r_bad, 0);
    run_op(2'd1, 16'hF900, 16'h3000, 1'b0, 0);
    chk("R3 no data ends", r_ticks, 25 + 6);
    chk("R3 no data takes", r_takes, 0);
    run_op(2'd1, 16'hF83C, 16'h4000, 1'b0, 5);
    chk("R3 word boundary ticks", r_ticks, 25 + 18 + 6);
    chk("R3 word boundary takes", r_takes, 1);
    run_op(2'd1, 16'hF87E, 16'h5000, 1'b1, 5);
    chk("R3 byte boundary ticks", r_ticks, 25 + 18 + 6);
    chk("R3 byte boundary takes", r_takes, 1);
    chk("R3 byte addr/data", r_bad, 0);

    // R6 lock after reset
    expect_reject("R6 word locked", 2'd0, 16'h10C4);
    expect_reject("R6 block locked", 2'd1, 16'h10E0);
    expect_reject("R6 erase locked", 2'd2, 16'h10FF);

    // R5 mass erase while locked
    run_op(2'd3, 16'h0000, 16'h0, 1'b0, 0);
    chk("R5 mass ticks", r_ticks, 10593);
    chk("R5 mass flags", {r_er, r_mass, r_keep}, 3'b111);

    // R6 unlock/relock
    pulse(1, 1);
    expect_reject("R6 relock wins", 2'd0, 16'h10C0);
    pulse(1, 0);
    run_op(2'd2, 16'h10D3, 16'h0, 1'b0, 0);
    chk("R6 unlocked erase base", r_addr, 16'h10C0);
    chk("R6 unlocked erase ticks", r_ticks, 4819);
    run_op(2'd3, 16'h0000, 16'h0, 1'b0, 0);
    chk("R5 mass unlocked keep", {r_mass, r_keep}, 2'b10);
    pulse(0, 1);
    expect_reject("R6 relocked", 2'd2, 16'h10C0);
    pulse(1, 0);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    expect_reject("R6 relock on reset", 2'd0, 16'h10C2);

    // R7 command while busy
    r_inj = 1;
    run_op(2'd2, 16'hFA10, 16'h0, 1'b0, 0);
    r_inj = 0;
    chk("R7 busy viol", r_viol, 1);
    chk("R7 addr kept", r_mid_addr, 16'hFA00);
    chk("R7 strobe kept", r_mid_er, 1);
    chk("R7 duration kept", r_ticks, 4819);
    chk("R7 done", r_done, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule